// File: doc/BRIEF.md
# Flow-Controlled Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial characters on a single line. A byte first lands in a one-entry holding register. When the bit engine is free, the byte moves into a shift register and goes out as a character. A character is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. A rate enable from outside the block, pulsing at sixteen times the bit rate, sets the bit timing. Word length, parity and stop count come from configuration inputs and are captured when each character starts.

An active-low clear-to-send input gates the transmitter. It passes through a two-stage synchronizer. While it is deasserted, any character already on the line still finishes in full. After that the line rests high and the holding register is not taken. The empty flag and the interrupt request both read low during this time. When the input returns low, a held byte starts on the next bit boundary. The holding-empty flag and the interrupt request tell the host when it may write the next byte.

Top module: `cts_serial_tx`

## Requirements
- R1: After synchronous reset, txd is 1, tdre is 1 and tx_irq is 0.
- R2: A write (wr_en high) fills the holding register: in the next cycle, tdre and tx_irq are both 0.
- R3: A bit boundary is a cycle in which tick16 is high and the internal tick count, which runs from reset, has reached 15. Each bit therefore lasts 16 ticks, and txd changes only in the cycle after a boundary.
- R4: A character is a start bit of 0 followed by the data bits, least significant first. cfg_len selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8.
- R5: With cfg_par_en high, a parity bit follows the data. With cfg_par_odd at 0 it is the XOR of the data bits (even parity). With cfg_par_odd at 1 it is the inverse of that XOR (odd parity).
- R6: A character ends with one stop bit of 1, or two stop bits when cfg_two_stop is high.
- R7: At a bit boundary with no character in progress, a full holding register and clear-to-send granted, the byte moves to the shifter. The start bit follows, and tdre and tx_irq rise.
- R8: When the holding register is full as the last stop bit ends, the next start bit follows with no idle bit between.
- R9: cts_n acts through a two-flop synchronizer. While the synchronized level is high, the current character completes, txd then stays 1, the holding register is not taken, and tdre and tx_irq read 0.
- R10: When the synchronized cts_n returns low with the holding register full, the character starts at the next bit boundary.
- R11: A write in the same cycle as a transfer sends the older byte. The new byte stays held, so tdre remains 0.
- R12: A write while the holding register is full replaces the held byte. Only the newer byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Rate enable at 16x the bit rate |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte to send |
| cfg_len | input | 2 | Data bit count code (5 + value) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cts_n | input | 1 | Clear to send, active low |
| txd | output | 1 | Serial line, idles at 1 |
| tdre | output | 1 | Holding register empty and clear to send granted |
| tx_irq | output | 1 | Transmit interrupt request, set by a transfer, cleared by a write |

## Verification
The assertions check on every cycle that txd only moves right after a bit boundary, that a transfer is always followed by a start bit, that a write always drops tdre, and that a held byte is never taken while the synchronized clear-to-send is deasserted. Other behaviour needs whole scenarios, compared cycle by cycle against a reference model that builds each character as a queue of line levels. That covers the bit ordering for every word length, the parity polarity, the stop count and back-to-back characters. It also covers a character that finishes while clear-to-send is withdrawn, the restart on the next boundary, and overwrite or same-cycle write races on the holding register.

// File: rtl/tx_pkg.sv
package tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP1,
        ST_STOP2
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       two_stop;
    } tx_cfg_t;

    function automatic logic [3:0] word_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/tx_tick_timer.sv
module tx_tick_timer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick16,
    output logic bit_edge
);
    localparam int CNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

    logic [CNT_W-1:0] phase;

    assign bit_edge = tick16 && (phase == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (tick16) begin
            if (phase == LAST) phase <= '0;
            else               phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    input  logic              cts_n,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data,
    output logic              cts_ok,
    output logic              tdre,
    output logic              tx_irq
);
    logic [SYNC_STAGES-1:0] cts_sync;
    logic                   irq_flag;

    always_ff @(posedge clk) begin
        if (rst) cts_sync <= '0;
        else     cts_sync <= {cts_sync[SYNC_STAGES-2:0], cts_n};
    end

    assign cts_ok = ~cts_sync[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_full <= 1'b0;
            hold_data <= '0;
            irq_flag  <= 1'b0;
        end else if (wr_en) begin
            hold_full <= 1'b1;
            hold_data <= wr_data;
            irq_flag  <= 1'b0;
        end else if (take) begin
            hold_full <= 1'b0;
            irq_flag  <= 1'b1;
        end
    end

    assign tdre   = ~hold_full & cts_ok;
    assign tx_irq = irq_flag & cts_ok;

    // R9: a held byte survives while clear-to-send is withdrawn
    p_hold_kept_r9: assert property (@(posedge clk) disable iff (rst)
        (hold_full && !cts_ok && !wr_en) |=> hold_full);

    // R2: a write always leaves the register non-empty
    p_tdre_low_after_write_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tdre);

endmodule

// File: rtl/tx_frame_fsm.sv
module tx_frame_fsm
    import tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_edge,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              cts_ok,
    input  tx_cfg_t           cfg,
    output logic              take,
    output logic              txd
);
    tx_state_e         state;
    logic [DATA_W-1:0] shifter;
    logic [3:0]        left;
    logic              par_acc;
    logic              q_par_en;
    logic              q_two_stop;
    logic              frame_done;

    assign frame_done = (state == ST_IDLE) ||
                        (state == ST_STOP1 && !q_two_stop) ||
                        (state == ST_STOP2);

    assign take = bit_edge && frame_done && hold_full && cts_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            shifter    <= '0;
            left       <= '0;
            par_acc    <= 1'b0;
            q_par_en   <= 1'b0;
            q_two_stop <= 1'b0;
            txd        <= 1'b1;
        end else if (bit_edge) begin
            if (take) begin
                shifter    <= hold_data;
                left       <= word_bits(cfg.len);
                par_acc    <= cfg.par_odd;
                q_par_en   <= cfg.par_en;
                q_two_stop <= cfg.two_stop;
                state      <= ST_START;
                txd        <= 1'b0;
            end else begin
                case (state)
                    ST_START, ST_DATA: begin
                        if (state == ST_DATA && left == 4'd0) begin
                            if (q_par_en) begin
                                txd   <= par_acc;
                                state <= ST_PAR;
                            end else begin
                                txd   <= 1'b1;
                                state <= ST_STOP1;
                            end
                        end else begin
                            txd     <= shifter[0];
                            par_acc <= par_acc ^ shifter[0];
                            shifter <= {1'b0, shifter[DATA_W-1:1]};
                            left    <= left - 4'd1;
                            state   <= ST_DATA;
                        end
                    end
                    ST_PAR: begin
                        txd   <= 1'b1;
                        state <= ST_STOP1;
                    end
                    ST_STOP1: begin
                        txd   <= 1'b1;
                        state <= q_two_stop ? ST_STOP2 : ST_IDLE;
                    end
                    default: begin
                        txd   <= 1'b1;
                        state <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    // R3: the line moves only right after a bit boundary
    p_txd_edge_only_r3: assert property (@(posedge clk) disable iff (rst)
        !bit_edge |=> $stable(txd));

    // R4: every transfer opens with a low start bit
    p_start_bit_r4: assert property (@(posedge clk) disable iff (rst)
        take |=> !txd);

endmodule

// File: rtl/cts_serial_tx.sv
module cts_serial_tx
    import tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              cts_n,
    output logic              txd,
    output logic              tdre,
    output logic              tx_irq
);
    logic              bit_edge;
    logic              take;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              cts_ok;
    tx_cfg_t           cfg;

    assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                   two_stop: cfg_two_stop};

    tx_tick_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick16   (tick16),
        .bit_edge (bit_edge)
    );

    tx_hold_reg #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .take      (take),
        .cts_n     (cts_n),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .cts_ok    (cts_ok),
        .tdre      (tdre),
        .tx_irq    (tx_irq)
    );

    tx_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bit_edge  (bit_edge),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .cts_ok    (cts_ok),
        .cfg       (cfg),
        .take      (take),
        .txd       (txd)
    );

endmodule

// File: tb/sim_cts_serial_tx.sv
`timescale 1ns/1ps
module sim_cts_serial_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       cts_n = 1'b0;
    logic       tick16;
    logic       txd, tdre, tx_irq;
    logic [31:0] cyc = 32'd0;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 32'd1;
    assign tick16 = cyc[0];

    cts_serial_tx u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .cts_n(cts_n),
        .txd(txd), .tdre(tdre), .tx_irq(tx_irq)
    );

    // reference model: each character becomes a queue of line levels
    bit   m_q[$];
    int   m_cnt;
    bit   m_line, m_full, m_irqf, m_s1, m_s2, m_edge, m_xfer, m_par;
    logic [7:0] m_hold;
    int   m_n;

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            m_cnt = 0; m_line = 1; m_full = 0; m_irqf = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            m_edge = tick16 && (m_cnt == 15);
            m_xfer = 0;
            if (tick16) m_cnt = (m_cnt + 1) % 16;
            if (m_edge) begin
                if (m_q.size() > 0) begin
                    m_line = m_q.pop_front();
                end else if (m_full && !m_s2) begin
                    m_xfer = 1;
                    m_n = 5 + int'(cfg_len);
                    m_par = cfg_par_odd;
                    m_q.push_back(1'b0);
                    for (int i = 0; i < m_n; i++) begin
                        m_q.push_back(m_hold[i]);
                        m_par = m_par ^ m_hold[i];
                    end
                    if (cfg_par_en) m_q.push_back(m_par);
                    m_q.push_back(1'b1);
                    if (cfg_two_stop) m_q.push_back(1'b1);
                    m_line = m_q.pop_front();
                end else begin
                    m_line = 1;
                end
            end
            if (wr_en) begin
                m_hold = wr_data; m_full = 1; m_irqf = 0;
            end else if (m_xfer) begin
                m_full = 0; m_irqf = 1;
            end
            m_s2 = m_s1;
            m_s1 = cts_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            check(txd == m_line, cur_req, txd, m_line, "txd");
            check(tdre == (!m_full && !m_s2), cur_req, tdre, (!m_full && !m_s2), "tdre");
            check(tx_irq == (m_irqf && !m_s2), cur_req, tx_irq, (m_irqf && !m_s2), "tx_irq");
        end
    end

    task automatic write_byte(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send(input logic [7:0] d);
        while (!tdre) @(negedge clk);
        write_byte(d);
    endtask

    task automatic drain();
        while (!tdre || m_q.size() > 0) @(negedge clk);
        repeat (40) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1", txd, 1, "txd after reset");
        check(tdre == 1'b1, "R1", tdre, 1, "tdre after reset");
        check(tx_irq == 1'b0, "R1", tx_irq, 0, "irq after reset");

        // R2 / R7 / R4: eight data bits, no parity, one stop
        cur_req = "R4";
        write_byte(8'hA5);
        check(tdre == 1'b0, "R2", tdre, 0, "tdre after write");
        check(tx_irq == 1'b0, "R2", tx_irq, 0, "irq after write");
        cur_req = "R7";
        while (!tdre) @(negedge clk);
        check(tx_irq == 1'b1, "R7", tx_irq, 1, "irq after transfer");
        cur_req = "R3";
        drain();

        // R5 even parity, R6 two stops, five bits
        cur_req = "R5";
        cfg_len = 2'd0; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_two_stop = 1'b1;
        send(8'h13);
        drain();
        cur_req = "R6";
        cfg_len = 2'd2; cfg_par_odd = 1'b1; cfg_two_stop = 1'b0;
        send(8'h55);
        drain();
        cfg_len = 2'd1;
        send(8'h2E);
        drain();

        // R8 back-to-back
        cur_req = "R8";
        cfg_len = 2'd3; cfg_par_en = 1'b0;
        send(8'h0F); send(8'hF0); send(8'h81);
        drain();

        // R9 clear-to-send withdrawn mid-character, R12 overwrite, R10 resume
        cur_req = "R9";
        send(8'h3C);
        repeat (100) @(negedge clk);
        cts_n = 1'b1;
        write_byte(8'h11);
        repeat (800) @(negedge clk);
        check(txd == 1'b1, "R9", txd, 1, "line idle while blocked");
        check(tdre == 1'b0, "R9", tdre, 0, "tdre while blocked");
        check(tx_irq == 1'b0, "R9", tx_irq, 0, "irq while blocked");
        cur_req = "R12";
        write_byte(8'hC3);
        repeat (40) @(negedge clk);
        cur_req = "R10";
        cts_n = 1'b0;
        drain();

        // R11 write coinciding with a transfer
        cur_req = "R11";
        send(8'h99);
        write_byte(8'h66);
        while (!(m_cnt == 15 && tick16 == 1'b1 && m_q.size() == 0 && m_full)) @(negedge clk);
        write_byte(8'h7E);
        check(tdre == 1'b0, "R11", tdre, 0, "new byte still held");
        check(txd == 1'b0, "R11", txd, 0, "older byte started");
        drain();

        finish_run();
    end

endmodule